// File: doc/BRIEF.md
# Query and Identifier Read Lane Replicator

This block builds the read word returned for identifier reads and query-table reads when several identical flash devices sit side by side on one data bus. A request carries the bus byte offset, the access width, the width of the whole bank, the width each device is driven at and the widest width that device supports natively. The block turns the bus offset into a per-device table index, fetches either an identifier code or one byte of the query table, and copies the single-device answer into every device lane of the bus word.

The query table is not stored here. It sits behind a synchronous read port with one cycle of latency, addressed by `tbl_addr` and answering on `tbl_data`. An access wider than the bank is split into one lookup per bank-wide chunk. Each lookup takes one cycle, and the lookup of one chunk overlaps the assembly of the chunk before it. When no device width is configured, a simpler compatibility path is used instead: it does one lookup and does no replication.

Top module: `qid_lane_rep`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0 and `rsp_data` is 0.
- R2: In the cycle after a request is accepted, `tbl_addr` carries the low bits of the first chunk's index. With a device width configured, the index is the chunk offset shifted right by `bank_lg + max_lg - dev_lg`. All width inputs use log2 codes: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes.
- R3: A query read (`req_kind`=1) whose index is at or above `TBL_LEN` yields zero for that chunk.
- R4: For query reads with `dev_lg` < `max_lg`, a byte-wide device (`dev_lg`=0) repeats the table byte in every lane. Any other reduced-width device (`dev_lg`>0) yields zero. When `dev_lg` = `max_lg`, the byte is zero-extended to the device width.
- R5: The single-device value is trimmed to its low device-width bytes. That slot is then copied into every device slot of the bank width.
- R6: For identifier reads (`req_kind`=0) with a device width configured, the low 8 bits of the index choose the value: 0 gives `id0`, 1 gives `id1`, and any other value gives 0.
- R7: When the access width exceeds the bank width, chunk i is looked up at offset `req_offset + i*bank bytes` and is packed at byte lane `i*bank bytes`, starting from the least significant lane. Bytes above the larger of the access width and the bank width are zero.
- R8: With `dev_width_set`=0, the index is `req_offset[7:0] >> bank_lg` and exactly one lookup is done. A query returns the table byte zero-extended, or 0 when the index is out of range. An identifier read returns `(id0<<8)|id1` at index 0, `(id2<<8)|id3` at index 1, and 0 at any other index.
- R9: A request with n chunks (n = 1 on the compatibility path) raises `busy` from the edge that accepts it. `rsp_valid` is a one-cycle pulse on the (n+1)-th rising edge after acceptance, and `busy` falls on that same edge.
- R10: `req_valid` while `busy` is 1 is ignored. It does not change the response in flight, and it produces no extra response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 1 | 0 identifier read, 1 query read |
| req_offset | input | ADDR_W | Bus byte offset |
| req_size_lg | input | 2 | log2 of access width in bytes |
| bank_lg | input | 2 | log2 of bank width in bytes |
| dev_lg | input | 2 | log2 of device width in bytes |
| max_lg | input | 2 | log2 of device maximum width in bytes |
| dev_width_set | input | 1 | 1 when a device width is configured |
| id0 | input | ID_W | Manufacturer code / compatibility code 0 |
| id1 | input | ID_W | Device code / compatibility code 1 |
| id2 | input | ID_W | Compatibility code 2 |
| id3 | input | ID_W | Compatibility code 3 |
| tbl_addr | output | TBL_AW | Query table read address |
| tbl_data | input | 8 | Query table byte, one cycle after address |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Response word ready (one cycle) |
| rsp_data | output | 32 | Assembled response word |

## Verification
On multi-chunk reads, the table lookup for chunk i+1 and the packing of chunk i happen in the same cycle. Bank-wide and byte-wide banks with access widths above the bank width force this overlap. The table model returns a byte derived from its address, so a chunk packed with the wrong index or the wrong cycle's data shows up as a wrong byte in a particular lane. A second request is also driven while one is in flight. It must neither disturb the response nor add one.

// File: rtl/qid_lane_pkg.sv
package qid_lane_pkg;

  typedef enum logic {
    KIND_ID  = 1'b0,
    KIND_QRY = 1'b1
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       legacy;
    logic [1:0] size_lg;
    logic [1:0] bank_lg;
    logic [1:0] dev_lg;
    logic [1:0] max_lg;
  } req_cfg_t;

  // copy the low device-width bytes of v into every slot of a 32-bit word
  function automatic logic [31:0] rep_lanes(input logic [31:0] v, input logic [1:0] dlg);
    case (dlg)
      2'd0:    rep_lanes = {4{v[7:0]}};
      2'd1:    rep_lanes = {2{v[15:0]}};
      default: rep_lanes = v;
    endcase
  endfunction

  function automatic logic [31:0] width_mask(input logic [1:0] wlg);
    case (wlg)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // number of bank-wide chunks minus one
  function automatic logic [1:0] chunks_m1(input logic [1:0] slg, input logic [1:0] blg);
    logic [1:0] d;
    d = slg - blg;
    if (slg > blg) chunks_m1 = (d == 2'd1) ? 2'd1 : 2'd3;
    else           chunks_m1 = 2'd0;
  endfunction

endpackage

// File: rtl/qid_lane_index.sv
module qid_lane_index
  import qid_lane_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] off,
  input  logic [1:0]        cnt,
  input  req_cfg_t          cfg,
  output logic [ADDR_W-1:0] idx
);

  logic [ADDR_W-1:0] chunk_off;
  logic [2:0]        sh;
  logic [7:0]        low_off;

  assign chunk_off = off + (ADDR_W'(cnt) << cfg.bank_lg);
  assign sh        = 3'(cfg.bank_lg) + 3'(cfg.max_lg) - 3'(cfg.dev_lg);
  assign low_off   = off[7:0] >> cfg.bank_lg;

  assign idx = cfg.legacy ? ADDR_W'(low_off) : (chunk_off >> sh);

endmodule

// File: rtl/qid_lane_chunk.sv
module qid_lane_chunk
  import qid_lane_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int TBL_LEN = 82,
  parameter int ID_W    = 16
) (
  input  req_cfg_t          cfg,
  input  logic [ADDR_W-1:0] idx,
  input  logic [7:0]        tbl_byte,
  input  logic [ID_W-1:0]   id0,
  input  logic [ID_W-1:0]   id1,
  input  logic [ID_W-1:0]   id2,
  input  logic [ID_W-1:0]   id3,
  output logic [31:0]       chunk
);

  localparam logic [ADDR_W-1:0] LEN_V = ADDR_W'(TBL_LEN);

  logic        in_rng;
  logic [31:0] one_dev;

  assign in_rng = idx < LEN_V;

  always_comb begin
    one_dev = '0;
    chunk   = '0;
    if (cfg.legacy) begin
      if (cfg.kind == KIND_QRY) begin
        if (in_rng) one_dev = {24'h0, tbl_byte};
      end else if (idx == '0) begin
        one_dev = (32'(id0) << 8) | 32'(id1);
      end else if (idx == ADDR_W'(1)) begin
        one_dev = (32'(id2) << 8) | 32'(id3);
      end
      chunk = one_dev;
    end else begin
      if (cfg.kind == KIND_QRY) begin
        if (!in_rng)                   one_dev = '0;
        else if (cfg.dev_lg != cfg.max_lg)
          one_dev = (cfg.dev_lg == 2'd0) ? {4{tbl_byte}} : 32'h0;
        else                           one_dev = {24'h0, tbl_byte};
      end else begin
        case (idx[7:0])
          8'd0:    one_dev = 32'(id0);
          8'd1:    one_dev = 32'(id1);
          default: one_dev = '0;
        endcase
      end
      chunk = rep_lanes(one_dev, cfg.dev_lg) & width_mask(cfg.bank_lg);
    end
  end

endmodule

// File: rtl/qid_lane_rep.sv
module qid_lane_rep
  import qid_lane_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int TBL_LEN = 82,
  parameter int ID_W    = 16,
  localparam int TBL_AW = $clog2(TBL_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_size_lg,
  input  logic [1:0]        bank_lg,
  input  logic [1:0]        dev_lg,
  input  logic [1:0]        max_lg,
  input  logic              dev_width_set,
  input  logic [ID_W-1:0]   id0,
  input  logic [ID_W-1:0]   id1,
  input  logic [ID_W-1:0]   id2,
  input  logic [ID_W-1:0]   id3,
  output logic [TBL_AW-1:0] tbl_addr,
  input  logic [7:0]        tbl_data,
  output logic              busy,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data
);

  req_cfg_t          cfg_q;
  logic [ADDR_W-1:0] off_q;
  logic              iss_act;
  logic [1:0]        iss_cnt;
  logic              rd_act;
  logic              rd_last;
  logic [1:0]        rd_cnt;
  logic [ADDR_W-1:0] rd_idx;
  logic [31:0]       acc;

  logic [ADDR_W-1:0] iss_idx;
  logic [31:0]       chunk;
  logic [31:0]       placed;
  logic [4:0]        lane_sh;
  logic [1:0]        n_m1;
  logic              accept;

  assign busy   = iss_act | rd_act;
  assign accept = req_valid & ~busy;
  assign n_m1   = cfg_q.legacy ? 2'd0 : chunks_m1(cfg_q.size_lg, cfg_q.bank_lg);

  qid_lane_index #(.ADDR_W(ADDR_W)) u_index (
    .off (off_q),
    .cnt (iss_cnt),
    .cfg (cfg_q),
    .idx (iss_idx)
  );

  assign tbl_addr = iss_idx[TBL_AW-1:0];

  qid_lane_chunk #(.ADDR_W(ADDR_W), .TBL_LEN(TBL_LEN), .ID_W(ID_W)) u_chunk (
    .cfg      (cfg_q),
    .idx      (rd_idx),
    .tbl_byte (tbl_data),
    .id0      (id0),
    .id1      (id1),
    .id2      (id2),
    .id3      (id3),
    .chunk    (chunk)
  );

  assign lane_sh = 5'({rd_cnt, 3'b000}) << cfg_q.bank_lg;
  assign placed  = cfg_q.legacy ? chunk : (chunk << lane_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      off_q     <= '0;
      iss_act   <= 1'b0;
      iss_cnt   <= '0;
      rd_act    <= 1'b0;
      rd_last   <= 1'b0;
      rd_cnt    <= '0;
      rd_idx    <= '0;
      acc       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        cfg_q.kind    <= kind_e'(req_kind);
        cfg_q.legacy  <= ~dev_width_set;
        cfg_q.size_lg <= req_size_lg;
        cfg_q.bank_lg <= bank_lg;
        cfg_q.dev_lg  <= dev_lg;
        cfg_q.max_lg  <= max_lg;
        off_q         <= req_offset;
        iss_act       <= 1'b1;
        iss_cnt       <= '0;
        acc           <= '0;
      end
      if (iss_act) begin
        rd_act  <= 1'b1;
        rd_idx  <= iss_idx;
        rd_cnt  <= iss_cnt;
        rd_last <= (iss_cnt == n_m1);
        if (iss_cnt == n_m1) iss_act <= 1'b0;
        else                 iss_cnt <= iss_cnt + 2'd1;
      end else begin
        rd_act <= 1'b0;
      end
      if (rd_act) begin
        acc <= acc | placed;
        if (rd_last) begin
          rsp_valid <= 1'b1;
          rsp_data  <= acc | placed;
        end
      end
    end
  end

endmodule

// File: rtl/qid_lane_rep_chk.sv
module qid_lane_rep_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic rsp_valid
);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R9
  done_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !rsp_valid) |=> !rsp_valid);

endmodule

bind qid_lane_rep qid_lane_rep_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .rsp_valid (rsp_valid)
);

// File: tb/qid_lane_rep_tb.sv
module qid_lane_rep_tb;

  localparam int ADDR_W  = 16;
  localparam int TBL_LEN = 82;
  localparam int ID_W    = 16;
  localparam int TBL_AW  = $clog2(TBL_LEN);

  localparam logic [15:0] ID0 = 16'hA189;
  localparam logic [15:0] ID1 = 16'h3C17;
  localparam logic [15:0] ID2 = 16'h5E02;
  localparam logic [15:0] ID3 = 16'h7744;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_kind = 1'b0;
  logic [ADDR_W-1:0] req_offset = '0;
  logic [1:0]        req_size_lg = '0;
  logic [1:0]        bank_lg = '0;
  logic [1:0]        dev_lg = '0;
  logic [1:0]        max_lg = '0;
  logic              dev_width_set = 1'b1;
  logic [TBL_AW-1:0] tbl_addr;
  logic [7:0]        tbl_data = '0;
  logic              busy;
  logic              rsp_valid;
  logic [31:0]       rsp_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  qid_lane_rep #(.ADDR_W(ADDR_W), .TBL_LEN(TBL_LEN), .ID_W(ID_W)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_offset    (req_offset),
    .req_size_lg   (req_size_lg),
    .bank_lg       (bank_lg),
    .dev_lg        (dev_lg),
    .max_lg        (max_lg),
    .dev_width_set (dev_width_set),
    .id0           (ID0),
    .id1           (ID1),
    .id2           (ID2),
    .id3           (ID3),
    .tbl_addr      (tbl_addr),
    .tbl_data      (tbl_data),
    .busy          (busy),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data)
  );

  function automatic logic [7:0] tbyte(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  // query table model: one cycle of read latency
  always @(posedge clk) tbl_data <= tbyte(int'(tbl_addr));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int chunk_num(input int sz, input int bk, input bit legacy);
    if (legacy) return 1;
    if (sz > bk) return 1 << (sz - bk);
    return 1;
  endfunction

  function automatic int first_idx(input int off, input int bk, input int dv, input int mx,
                                   input bit legacy);
    if (legacy) return (off & 255) >> bk;
    return off >> (bk + mx - dv);
  endfunction

  function automatic logic [31:0] expect_word(input bit kind, input int off, input int sz,
                                              input int bk, input int dv, input int mx,
                                              input bit legacy);
    logic [31:0] res;
    logic [31:0] one;
    int idx, o, bw, dw;
    res = '0;
    bw = 1 << bk;
    dw = 1 << dv;
    if (legacy) begin
      idx = (off & 255) >> bk;
      if (kind) res = (idx < TBL_LEN) ? {24'h0, tbyte(idx)} : 32'h0;
      else if (idx == 0) res = {8'h0, ID0, 8'h0} | {16'h0, ID1};
      else if (idx == 1) res = {8'h0, ID2, 8'h0} | {16'h0, ID3};
      return res;
    end
    for (int c = 0; c < chunk_num(sz, bk, 1'b0); c++) begin
      o   = (off + c * bw) & 16'hFFFF;
      idx = o >> (bk + mx - dv);
      one = '0;
      if (kind) begin
        if (idx >= TBL_LEN) one = '0;
        else if (dv != mx) one = (dv == 0) ? {4{tbyte(idx)}} : 32'h0;
        else one = {24'h0, tbyte(idx)};
      end else begin
        if ((idx & 255) == 0) one = {16'h0, ID0};
        else if ((idx & 255) == 1) one = {16'h0, ID1};
      end
      for (int j = 0; j < bw; j++)
        res[(c * bw + j) * 8 +: 8] = one[(j % dw) * 8 +: 8];
    end
    return res;
  endfunction

  // issue one request; optional second request while busy
  task automatic run_req(input string tag, input bit kind, input int off, input int sz,
                         input int bk, input int dv, input int mx, input bit legacy,
                         input bit poke);
    int n, k;
    logic [31:0] exp;
    n   = chunk_num(sz, bk, legacy);
    exp = expect_word(kind, off, sz, bk, dv, mx, legacy);
    @(negedge clk);
    req_valid     = 1'b1;
    req_kind      = kind;
    req_offset    = 16'(off);
    req_size_lg   = 2'(sz);
    bank_lg       = 2'(bk);
    dev_lg        = 2'(dv);
    max_lg        = 2'(mx);
    dev_width_set = ~legacy;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R9 busy after accept"}, {31'h0, busy}, 32'h1);
    // R2 index of first chunk on table address
    check({tag, " R2 table index"}, {25'h0, tbl_addr},
          {25'h0, 7'(first_idx(off, bk, dv, mx, legacy))});
    if (poke) begin
      // R10 request while busy must be dropped
      req_valid   = 1'b1;
      req_kind    = ~kind;
      req_offset  = 16'h0002;
      bank_lg     = 2'd0;
      req_size_lg = 2'd2;
    end
    k = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      k++;
    end while (!rsp_valid && k < 20);
    check({tag, " R9 latency"}, 32'(k), 32'(n + 1));
    check({tag, " data"}, rsp_data, exp);
    check({tag, " R9 busy low at response"}, {31'h0, busy}, 32'h0);
    @(negedge clk);
    check({tag, " R9 single pulse"}, {31'h0, rsp_valid}, 32'h0);
    if (poke) begin
      @(negedge clk);
      check({tag, " R10 no extra response"}, {30'h0, busy, rsp_valid}, 32'h0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {rsp_data[30:0], busy} | {31'h0, rsp_valid}, 32'h0);

    // R5 byte devices on a 4-byte bank
    run_req("R5 replicate x4", 1'b1, 16'h0040, 2, 2, 0, 0, 1'b0, 1'b0);
    // R5 16-bit devices on a 4-byte bank, identifier
    run_req("R5 R6 id0 x2", 1'b0, 16'h0000, 2, 2, 1, 1, 1'b0, 1'b0);
    // R4 wide part in byte mode repeats
    run_req("R4 byte mode", 1'b1, 16'h0080, 2, 2, 0, 1, 1'b0, 1'b0);
    // R4 native width zero-extends
    run_req("R4 native pad", 1'b1, 16'h0022, 1, 1, 1, 1, 1'b0, 1'b0);
    // R4 unsupported reduced width gives zero
    run_req("R4 unsupported", 1'b1, 16'h0040, 2, 2, 1, 2, 1'b0, 1'b0);
    // R3 boundary: last in-range and first out-of-range index
    run_req("R3 last entry", 1'b1, 16'h0051, 0, 0, 0, 0, 1'b0, 1'b0);
    run_req("R3 past end", 1'b1, 16'h0052, 0, 0, 0, 0, 1'b0, 1'b0);
    // R6 identifier selection
    run_req("R6 id1", 1'b0, 16'h0001, 0, 0, 0, 0, 1'b0, 1'b0);
    run_req("R6 other", 1'b0, 16'h0002, 0, 0, 0, 0, 1'b0, 1'b0);
    run_req("R6 low8 wrap", 1'b0, 16'h0100, 0, 0, 0, 0, 1'b0, 1'b0);
    // R7 wide access split into chunks
    run_req("R7 four chunks", 1'b1, 16'h0010, 2, 0, 0, 0, 1'b0, 1'b0);
    run_req("R7 two chunks", 1'b0, 16'h0000, 2, 1, 0, 0, 1'b0, 1'b0);
    run_req("R7 narrow access", 1'b1, 16'h0020, 0, 2, 0, 0, 1'b0, 1'b0);
    // R8 compatibility path
    run_req("R8 query", 1'b1, 16'h0022, 2, 1, 0, 0, 1'b1, 1'b0);
    run_req("R8 id pair0", 1'b0, 16'h0100, 2, 2, 0, 0, 1'b1, 1'b0);
    run_req("R8 id pair1", 1'b0, 16'h0004, 2, 2, 0, 0, 1'b1, 1'b0);
    run_req("R8 id other", 1'b0, 16'h0008, 2, 2, 0, 0, 1'b1, 1'b0);
    // R10 request while busy
    run_req("R10 overlap", 1'b1, 16'h0030, 2, 0, 0, 0, 1'b0, 1'b1);

    for (int t = 0; t < 300; t++) begin
      int bk, dv, mx, sz, off, sh;
      bit kind, leg;
      bk   = int'($urandom % 3);
      dv   = int'($urandom % (bk + 1));
      mx   = dv + int'($urandom % (3 - dv));
      sz   = int'($urandom % 3);
      kind = 1'($urandom % 2);
      leg  = (($urandom % 6) == 0);
      sh   = bk + mx - dv;
      if ($urandom % 2) off = int'($urandom % (TBL_LEN << sh));
      else              off = int'($urandom % 65536);
      if (leg && ($urandom % 2)) off = off & 16'h000F;
      run_req("R5/R7 random", kind, off, sz, bk, dv, mx, leg, (t % 10) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule